// File: doc/BRIEF.md
# Buffered Input Capture Timer

This block is a free-running up-counter with four input capture registers. Each register has its own input pin and copies the counter when a chosen edge appears on that pin. The registers form two pairs: A with C, and B with D. When a pair is switched to buffered mode, the second register of the pair stops listening to its own pin. On every capture of the first register it takes over the value the first register held before. Software can then read two successive timestamps of one pin.

If the two edge bits of a buffered pair differ, the first register captures on both edges of its pin. This measures high and low times with a single input. A capture that would land in a cycle where software reads any capture register waits until the first cycle without such a read, so a read never sees a register change under it. Each capture sets a sticky flag. The flag is cleared by a write of 0 to it, but only after it has been read as 1.

Top module: `frt_capture_top`

## Requirements
- R1: The counter (address 0) is CNT_W bits wide, increments by one on every clock and wraps to 0 after its all-ones value.
- R2: A write to address 0 loads the counter with the write data, and the write takes priority over the increment in that cycle.
- R3: Pins pass a two-flop synchronizer. A pin level sampled at clock edge k that forms the selected edge updates its capture register at edge k+2, with the counter value present just before that edge. Edge bit 1 selects rising and 0 selects falling.
- R4: With buffering off, registers C (address 3) and D (address 4) capture independently from pins 2 and 3, using their own edge bits.
- R5: With buffering on for a pair, each capture of the main register moves its old value into the buffer register at the same edge. The buffer register's own pin is then ignored, and its flag is not set by the transfer.
- R6: With buffering on and the main and buffer edge bits different, the main register captures on both rising and falling edges of its pin.
- R7: A capture due in a cycle where rd_en_i is high with address 1 to 4 is postponed to the first later cycle without such a read. It then captures the counter value of that cycle.
- R8: Each capture sets a sticky flag (flag_o and address 6, bits 0..3 for A..D). Writing 0 to a flag bit clears it only if that bit was read as 1 at address 6 earlier. Writing 1, or writing 0 without a prior read, has no effect. A capture in the clearing cycle keeps the flag set.
- R9: The control register at address 5 holds the edge bits for A, B, C, D in bits 0..3, the A/C buffer enable in bit 4 and the B/D buffer enable in bit 5. rdata_o is a combinational read of the register selected by addr_i.
- R10: After reset the counter, all capture registers, control bits and flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_pin_i | input | 4 | Capture pins for A, B, C, D |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (marks a read access) |
| addr_i | input | 3 | Register address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for addr_i |
| flag_o | output | 4 | Capture flags A..D |

## Verification
A capture is due two edges after the edge that samples the pin change. A delayed capture is due at the first edge without a capture read. Counter loads, control writes and flag updates are due at the next edge. The bench model advances one step per rising edge from the inputs held over that cycle. It compares rdata_o and flag_o 5 ns after the edge, so every result is checked in the exact cycle it becomes due. Between stimuli the bench sweeps addr_i with rd_en_i low, so that every register is compared without triggering the read delay.

// File: rtl/frt_pkg.sv
package frt_pkg;
  typedef enum logic [2:0] {
    ADDR_CNT   = 3'd0,
    ADDR_CAP_A = 3'd1,
    ADDR_CAP_B = 3'd2,
    ADDR_CAP_C = 3'd3,
    ADDR_CAP_D = 3'd4,
    ADDR_CTRL  = 3'd5,
    ADDR_FLAG  = 3'd6
  } addr_e;

  typedef struct packed {
    logic       buf_bd;
    logic       buf_ac;
    logic [3:0] edge_sel;  // 1 rising, 0 falling; A,B,C,D
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/frt_edge_det.sv
module frt_edge_det #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic s1, s2, prev;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1   <= 1'b0;
        s2   <= 1'b0;
        prev <= 1'b0;
      end else begin
        s1   <= pin_i[g];
        s2   <= s1;
        prev <= s2;
      end
    end
    assign rise_o[g] = s2 & ~prev;
    assign fall_o[g] = ~s2 & prev;
  end
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (ld_i) cnt_o <= ld_val_i;
    else           cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/frt_cap_pair.sv
module frt_cap_pair #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         buf_en_i,
  input  logic         edge_main_i,
  input  logic         edge_aux_i,
  input  logic [1:0]   rise_i,   // [0] main pin, [1] aux pin
  input  logic [1:0]   fall_i,
  input  logic         hold_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] main_o,
  output logic [W-1:0] aux_o,
  output logic [1:0]   set_o
);
  logic ev_main, ev_aux, go_main, go_aux, pend_main, pend_aux;

  always_comb begin
    if (buf_en_i && (edge_main_i != edge_aux_i)) ev_main = rise_i[0] | fall_i[0];
    else                                         ev_main = edge_main_i ? rise_i[0] : fall_i[0];
    ev_aux  = !buf_en_i && (edge_aux_i ? rise_i[1] : fall_i[1]);
    go_main = (ev_main | pend_main) & ~hold_i;
    go_aux  = (ev_aux | pend_aux) & ~hold_i & ~buf_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_main <= 1'b0;
      pend_aux  <= 1'b0;
      main_o    <= '0;
      aux_o     <= '0;
    end else begin
      pend_main <= (ev_main | pend_main) & hold_i;
      pend_aux  <= (ev_aux | pend_aux) & hold_i & ~buf_en_i;
      if (go_main) begin
        main_o <= cnt_i;
        if (buf_en_i) aux_o <= main_o;
      end
      if (go_aux) aux_o <= cnt_i;
    end
  end

  assign set_o = {go_aux, go_main};
endmodule

// File: rtl/frt_capture_top.sv
module frt_capture_top
  import frt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       cap_pin_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [2:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic [3:0]       flag_o
);
  localparam int NPIN = 4;
  localparam int NPAIR = NPIN / 2;

  ctrl_t            ctrl_q;
  logic [NPIN-1:0]  flag_q, arm_q, set_v, clr_v, rise, fall;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cap [NPIN];
  logic             hold, cnt_ld;
  logic [NPAIR-1:0] buf_en;

  assign hold   = rd_en_i && (addr_i >= ADDR_CAP_A) && (addr_i <= ADDR_CAP_D);
  assign cnt_ld = wr_en_i && (addr_i == ADDR_CNT);
  assign buf_en = {ctrl_q.buf_bd, ctrl_q.buf_ac};

  frt_counter #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(cnt_ld), .ld_val_i(wdata_i), .cnt_o(cnt)
  );

  frt_edge_det #(.N(NPIN)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(cap_pin_i), .rise_o(rise), .fall_o(fall)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic [1:0] set_p;
    frt_cap_pair #(.W(CNT_W)) u_pair (
      .clk_i(clk_i), .rst_ni(rst_ni), .buf_en_i(buf_en[p]),
      .edge_main_i(ctrl_q.edge_sel[p]), .edge_aux_i(ctrl_q.edge_sel[p+NPAIR]),
      .rise_i({rise[p+NPAIR], rise[p]}), .fall_i({fall[p+NPAIR], fall[p]}),
      .hold_i(hold), .cnt_i(cnt),
      .main_o(cap[p]), .aux_o(cap[p+NPAIR]), .set_o(set_p)
    );
    assign set_v[p]       = set_p[0];
    assign set_v[p+NPAIR] = set_p[1];
  end

  assign clr_v = (wr_en_i && addr_i == ADDR_FLAG) ? (arm_q & ~wdata_i[NPIN-1:0]) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      if (wr_en_i && addr_i == ADDR_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
      flag_q <= (flag_q & ~clr_v) | set_v;
      arm_q  <= (arm_q | ((rd_en_i && addr_i == ADDR_FLAG) ? flag_q : '0)) & ~clr_v;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CNT:   rdata_o = cnt;
      ADDR_CAP_A: rdata_o = cap[0];
      ADDR_CAP_B: rdata_o = cap[1];
      ADDR_CAP_C: rdata_o = cap[2];
      ADDR_CAP_D: rdata_o = cap[3];
      ADDR_CTRL:  rdata_o = CNT_W'(ctrl_q);
      ADDR_FLAG:  rdata_o = CNT_W'(flag_q);
      default:    rdata_o = '0;
    endcase
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/frt_capture_checker.sv
module frt_capture_checker #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ld,
  input logic [W-1:0] ld_val,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cap_a,
  input logic [W-1:0] cap_b,
  input logic [W-1:0] cap_c,
  input logic [W-1:0] cap_d,
  input logic         buf_ac,
  input logic         buf_bd,
  input logic         hold,
  input logic [3:0]   flag
);
  a_r1_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld |=> cnt == $past(cnt) + 1'b1);

  a_r2_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> cnt == $past(ld_val));

  a_r7_read_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> $stable(cap_a) && $stable(cap_b) && $stable(cap_c) && $stable(cap_d));

  a_r5_shift_ac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_ac ##1 (cap_a != $past(cap_a)) |-> cap_c == $past(cap_a));

  a_r5_shift_bd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_bd ##1 (cap_b != $past(cap_b)) |-> cap_d == $past(cap_b));

  a_r8_flag_a_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_a != $past(cap_a)) |-> flag[0]);

  a_r8_flag_b_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_b != $past(cap_b)) |-> flag[1]);
endmodule

bind frt_capture_top frt_capture_checker #(.W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ld(cnt_ld), .ld_val(wdata_i), .cnt(cnt),
  .cap_a(cap[0]), .cap_b(cap[1]), .cap_c(cap[2]), .cap_d(cap[3]),
  .buf_ac(ctrl_q.buf_ac), .buf_bd(ctrl_q.buf_bd), .hold(hold), .flag(flag_q)
);

// File: tb/tb_frt_capture_top.sv
`timescale 1ns/1ps
module tb_frt_capture_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pin = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  flag;

  int    n_run = 0, n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R10";

  always #10 clk = ~clk;

  frt_capture_top #(.CNT_W(16)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cap_pin_i(pin), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .flag_o(flag)
  );

  // behavioural reference
  logic [15:0] m_cnt;
  logic [15:0] m_cap [4];
  logic [3:0]  m_flag, m_arm, m_pend;
  logic [5:0]  m_ctrl;
  logic [3:0]  h0, h1, h2;  // pin samples 1, 2 and 3 edges ago

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt;
      3'd1, 3'd2, 3'd3, 3'd4: return m_cap[a-1];
      3'd5: return {10'd0, m_ctrl};
      3'd6: return {12'd0, m_flag};
      default: return 16'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_flag = 0; m_arm = 0; m_pend = 0; m_ctrl = 0;
      h0 = 0; h1 = 0; h2 = 0;
      for (int i = 0; i < 4; i++) m_cap[i] = 0;
    end else begin
      logic        hold_r;
      logic [3:0]  rise, fall, setv, clr, npend;
      logic [15:0] ncap [4];
      hold_r = rd_en && addr >= 1 && addr <= 4;
      rise = h1 & ~h2;
      fall = ~h1 & h2;
      setv = 0; npend = 0;
      for (int i = 0; i < 4; i++) ncap[i] = m_cap[i];
      for (int k = 0; k < 2; k++) begin
        bit bf, em, ea, evm, eva, gm, ga;
        bf = m_ctrl[4+k]; em = m_ctrl[k]; ea = m_ctrl[k+2];
        evm = (bf && em != ea) ? (rise[k] | fall[k]) : (em ? rise[k] : fall[k]);
        eva = !bf && (ea ? rise[k+2] : fall[k+2]);
        gm = (evm | m_pend[k]) && !hold_r;
        ga = (eva | m_pend[k+2]) && !hold_r && !bf;
        npend[k]   = (evm | m_pend[k]) && hold_r;
        npend[k+2] = (eva | m_pend[k+2]) && hold_r && !bf;
        if (gm) begin ncap[k] = m_cnt; if (bf) ncap[k+2] = m_cap[k]; end
        if (ga) ncap[k+2] = m_cnt;
        setv[k] = gm; setv[k+2] = ga;
      end
      clr = (wr_en && addr == 6) ? (m_arm & ~wdata[3:0]) : 4'd0;
      m_arm  = (m_arm | ((rd_en && addr == 6) ? m_flag : 4'd0)) & ~clr;
      m_flag = (m_flag & ~clr) | setv;
      m_pend = npend;
      for (int i = 0; i < 4; i++) m_cap[i] = ncap[i];
      if (wr_en && addr == 5) m_ctrl = wdata[5:0];
      m_cnt = (wr_en && addr == 0) ? wdata : m_cnt + 16'd1;
      h2 = h1; h1 = h0; h0 = pin;
    end
    #5;
    n_run++;
    if (rdata !== m_read(addr)) begin
      n_fail++;
      $display("FAIL %s: addr %0d rdata actual %h expected %h", cur_req, addr, rdata, m_read(addr));
    end
    n_run++;
    if (flag !== m_flag) begin
      n_fail++;
      $display("FAIL R8 (%s): flag_o actual %b expected %b", cur_req, flag, m_flag);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 0; rd_en = 0; addr = 3'(i % 7);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; rd_en = 0; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk); rd_en = 1; wr_en = 0; addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse(input int p, input int hi, input int lo);
    @(negedge clk); pin[p] = 1'b1;
    idle(hi);
    @(negedge clk); pin[p] = 1'b0;
    idle(lo);
  endtask

  initial begin
    cur_req = "R10";
    idle(4);
    @(negedge clk); rst_n = 1'b1;
    cur_req = "R1"; idle(20);
    cur_req = "R2"; wr(3'd0, 16'hFFF0); idle(30);
    cur_req = "R9"; wr(3'd5, 16'h0001); idle(7);
    cur_req = "R3"; pulse(0, 6, 8); pulse(0, 3, 9);
    wr(3'd5, 16'h0000); pulse(0, 5, 8); pulse(1, 4, 9);
    cur_req = "R4"; wr(3'd5, 16'h000C);
    pulse(2, 5, 7); pulse(3, 3, 8); pulse(0, 4, 8);
    cur_req = "R8";
    wr(3'd6, 16'h0000); idle(7);
    rd(3'd6); wr(3'd6, 16'h000A); idle(7);
    wr(3'd6, 16'h0000); idle(7);
    cur_req = "R5"; wr(3'd5, 16'h0013);
    pulse(0, 4, 9); pulse(2, 4, 9); pulse(0, 6, 9); pulse(0, 3, 9);
    cur_req = "R6"; wr(3'd5, 16'h0039);
    pulse(0, 5, 9); pulse(0, 7, 9); pulse(1, 4, 9); pulse(1, 6, 9);
    cur_req = "R7"; wr(3'd5, 16'h000F);
    @(negedge clk); pin[0] = 1'b1;
    @(negedge clk); @(negedge clk); rd_en = 1; addr = 3'd1;
    @(negedge clk); rd_en = 0; idle(8);
    @(negedge clk); pin[1] = 1'b1; pin[2] = 1'b1;
    @(negedge clk); @(negedge clk); rd_en = 1; addr = 3'd3;
    @(negedge clk); addr = 3'd2;
    @(negedge clk); addr = 3'd4;
    @(negedge clk); rd_en = 0; idle(10);
    rd(3'd6); wr(3'd6, 16'h0000); idle(8);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule